// File: doc/BRIEF.md
# Clock-Synchronous Serial Port with Ready Handshake

This block moves 8-bit frames over a three-wire synchronous link: shift clock, data out and data in. It can run as the master, making its own shift clock from the system clock through a divider, or as a slave, following a shift clock that another device drives. Software sets it up through a two-register bus. A control register holds the mode, one enable bit for each direction, the two trigger bits, the interrupt flag and the level of the handshake pin. A data register takes the byte to send on a write and returns the last byte received on a read.

A transfer starts when software writes a trigger bit whose direction is enabled. Both triggers may be set together, which gives a full-duplex frame. Bits leave and arrive least significant first. Outgoing data changes on the falling edge of the shift clock and incoming data is sampled on the rising edge. When the eighth bit has been sampled, the trigger bits drop back to zero and the interrupt line goes high. In slave mode the block drives a ready line that is high while the port is idle or busy and low while it is armed and waiting. This tells the external master when it may start clocking. In master mode the block does not drive that pin, and its level can be read in the control register so that firmware can watch a slave's ready line.

Top module: `sync_serial_port`

## Requirements
- R1: In slave mode, rdy_o is 1 while the port is idle. It is 0 from the clock edge that accepts a trigger write until the first falling edge of sclk_i.
- R2: In slave mode, rdy_o returns to 1 within 4 system clock cycles of the first falling edge of sclk_i after a trigger.
- R3: In master mode, rdy_oe_o is 0 and sclk_oe_o is 1, and control bit 5 reads the level of rdy_i. In slave mode, rdy_oe_o is 1 and sclk_oe_o is 0.
- R4: A frame carries exactly DATA_W bits with the least significant bit first, both on sdo_o and on sdi_i.
- R5: Control bits 3 (transmit trigger) and 4 (receive trigger) read 1 from the accepted trigger write until the frame ends, then read 0.
- R6: irq_o goes to 1 when the last bit of a frame has been sampled. Writing control with bit 6 set clears it.
- R7: A trigger write takes effect only when the enable for that direction (control bit 1 for transmit, bit 2 for receive) is 1 in the same write. Otherwise no transfer starts and no shift clock is produced.
- R8: In master mode (control bit 0 = 1), a frame produces exactly DATA_W shift clock pulses, each phase HALF_DIV system clocks long, and sclk_o stays high between frames.
- R9: The data register (address 1) read value changes only when a frame with the receive direction enabled completes. Frames with transmit only, and frames still in progress, leave it unchanged.
- R10: The transmitted byte is the data register value at the moment of the trigger. Writes to the data register during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 data |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational on reg_addr_i) |
| irq_o | output | 1 | Frame-complete interrupt |
| sclk_i | input | 1 | Shift clock from external master (slave mode) |
| sclk_o | output | 1 | Shift clock driven in master mode, idle high |
| sclk_oe_o | output | 1 | Shift clock output enable (master mode) |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| rdy_i | input | 1 | Level of the handshake pin, readable in control bit 5 |
| rdy_o | output | 1 | Ready/busy handshake, low when armed (slave mode) |
| rdy_oe_o | output | 1 | Handshake output enable (slave mode) |

## Verification
The bench builds the port with DATA_W = 8 and HALF_DIV = 2. The short divider keeps each master frame to 32 system clocks, so a single run can cover many master frames and count every shift clock pulse. The bench drives the slave shift clock at twelve system clocks per period, which is comfortably above the four-to-one ratio that the synchronizer needs. This leaves room to sample sdo_o and rdy_o between the synchronized edges, both at the first falling edge and in the middle of a frame.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_DATA = 1'b1
  } reg_sel_e;

  localparam int unsigned CB_MASTER = 0;
  localparam int unsigned CB_TX_EN  = 1;
  localparam int unsigned CB_RX_EN  = 2;
  localparam int unsigned CB_TX_GO  = 3;
  localparam int unsigned CB_RX_GO  = 4;
  localparam int unsigned CB_PIN    = 5;
  localparam int unsigned CB_IRQ    = 6;
  localparam int unsigned CTRL_BITS = 7;

  typedef struct packed {
    logic rx_en;
    logic tx_en;
    logic master;
  } cfg_t;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic run_i,
  input  logic sclk_i,
  output logic sclk_o,
  output logic fall_o,
  output logic rise_o
);
  localparam int unsigned CNT_W = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);
  localparam int unsigned SYNC_N = 3;

  logic [CNT_W-1:0]  div_q;
  logic              sclk_q;
  logic              tick;
  logic [SYNC_N-1:0] sync_q;
  logic              ext_fall, ext_rise;

  assign tick = run_i && master_i && (div_q == CNT_LAST);

  // master: divided clock, parked high whenever idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!run_i || !master_i) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else if (tick) begin
      div_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // slave: two synchronizer flops plus one history flop for edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_N-2:0], sclk_i};
  end

  assign ext_fall = sync_q[SYNC_N-1] & ~sync_q[SYNC_N-2];
  assign ext_rise = ~sync_q[SYNC_N-1] & sync_q[SYNC_N-2];

  assign sclk_o = sclk_q;
  assign fall_o = master_i ? (tick & sclk_q)  : ext_fall;
  assign rise_o = master_i ? (tick & ~sclk_q) : ext_rise;
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tx_go_i,
  input  logic              rx_go_i,
  input  logic [DATA_W-1:0] load_i,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic              sdi_i,
  output logic              tx_busy_o,
  output logic              rx_busy_o,
  output logic              sdo_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_word_o
);
  localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sh, rx_sh, rx_next;
  logic [CNT_W-1:0]  bit_q;
  logic              busy, last;

  assign busy    = tx_busy_o | rx_busy_o;
  assign last    = bit_q == BIT_LAST;
  assign rx_next = {sdi_i, rx_sh[DATA_W-1:1]};
  assign done_o  = busy & rise_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_busy_o <= 1'b0;
      rx_busy_o <= 1'b0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      bit_q     <= '0;
      sdo_o     <= 1'b1;
      rx_word_o <= '0;
    end else if (start_i) begin
      tx_busy_o <= tx_go_i;
      rx_busy_o <= rx_go_i;
      tx_sh     <= load_i;
      bit_q     <= '0;
    end else if (busy) begin
      if (fall_i && tx_busy_o) begin
        sdo_o <= tx_sh[0];
        tx_sh <= tx_sh >> 1;
      end
      if (rise_i) begin
        rx_sh <= rx_next;
        if (last) begin
          bit_q     <= '0;
          tx_busy_o <= 1'b0;
          rx_busy_o <= 1'b0;
          if (rx_busy_o) rx_word_o <= rx_next;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ssp_regs.sv
module ssp_regs
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pin_i,
  input  logic              tx_busy_i,
  input  logic              rx_busy_i,
  input  logic              done_i,
  input  logic              fall_i,
  input  logic [DATA_W-1:0] rx_word_i,
  output cfg_t              cfg_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              start_o,
  output logic              tx_go_o,
  output logic              rx_go_o,
  output logic              rdy_o,
  output logic              irq_o
);
  logic ctrl_wr, data_wr, busy;
  logic unused_wbits;

  assign busy    = tx_busy_i | rx_busy_i;
  assign ctrl_wr = we_i && (reg_sel_e'(addr_i) == SEL_CTRL);
  assign data_wr = we_i && (reg_sel_e'(addr_i) == SEL_DATA);
  assign tx_go_o = wdata_i[CB_TX_GO] & wdata_i[CB_TX_EN];
  assign rx_go_o = wdata_i[CB_RX_GO] & wdata_i[CB_RX_EN];
  assign start_o = ctrl_wr && !busy && (tx_go_o || rx_go_o);
  assign unused_wbits = ^{wdata_i[CB_PIN], wdata_i[DATA_W-1:CTRL_BITS]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o     <= '0;
      tx_data_o <= '0;
      irq_o     <= 1'b0;
      rdy_o     <= 1'b1;
    end else begin
      if (ctrl_wr) begin
        cfg_o.master <= wdata_i[CB_MASTER];
        cfg_o.tx_en  <= wdata_i[CB_TX_EN];
        cfg_o.rx_en  <= wdata_i[CB_RX_EN];
      end
      if (data_wr) tx_data_o <= wdata_i;
      if (done_i)                          irq_o <= 1'b1;
      else if (ctrl_wr && wdata_i[CB_IRQ]) irq_o <= 1'b0;
      // ready: low once armed as slave, high again on the first shift clock fall
      if (start_o && !wdata_i[CB_MASTER]) rdy_o <= 1'b0;
      else if (fall_i && busy)            rdy_o <= 1'b1;
    end
  end

  always_comb begin
    if (reg_sel_e'(addr_i) == SEL_DATA) begin
      rdata_o = rx_word_i;
    end else begin
      rdata_o = DATA_W'({irq_o, pin_i, rx_busy_i, tx_busy_i,
                         cfg_o.rx_en, cfg_o.tx_en, cfg_o.master});
    end
  end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HALF_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic              rdy_i,
  output logic              rdy_o,
  output logic              rdy_oe_o
);
  cfg_t              cfg;
  logic              master, busy, tx_busy, rx_busy;
  logic              start, tx_go, rx_go, done;
  logic              fall_ev, rise_ev;
  logic [DATA_W-1:0] tx_data, rx_word;

  assign master    = cfg.master;
  assign busy      = tx_busy | rx_busy;
  assign sclk_oe_o = master;
  assign rdy_oe_o  = ~master;

  ssp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .pin_i     (rdy_i),
    .tx_busy_i (tx_busy),
    .rx_busy_i (rx_busy),
    .done_i    (done),
    .fall_i    (fall_ev),
    .rx_word_i (rx_word),
    .cfg_o     (cfg),
    .tx_data_o (tx_data),
    .start_o   (start),
    .tx_go_o   (tx_go),
    .rx_go_o   (rx_go),
    .rdy_o     (rdy_o),
    .irq_o     (irq_o)
  );

  ssp_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .master_i (master),
    .run_i    (busy),
    .sclk_i   (sclk_i),
    .sclk_o   (sclk_o),
    .fall_o   (fall_ev),
    .rise_o   (rise_ev)
  );

  ssp_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .tx_go_i   (tx_go),
    .rx_go_i   (rx_go),
    .load_i    (tx_data),
    .fall_i    (fall_ev),
    .rise_i    (rise_ev),
    .sdi_i     (sdi_i),
    .tx_busy_o (tx_busy),
    .rx_busy_o (rx_busy),
    .sdo_o     (sdo_o),
    .done_o    (done),
    .rx_word_o (rx_word)
  );
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic master,
  input logic busy,
  input logic fall_ev,
  input logic rise_ev,
  input logic sclk_o,
  input logic rdy_o,
  input logic irq_o
);
  localparam int unsigned PW = $clog2(DATA_W + 1) + 1;
  logic [PW-1:0] pulses;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pulses <= '0;
    else if (!busy)             pulses <= '0;
    else if (fall_ev && master) pulses <= pulses + 1'b1;
  end

  a_r1_armed_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) && !master |-> !rdy_o);

  a_r2_rise_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> $past(fall_ev && busy));

  a_r5_end_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> $past(rise_ev));

  a_r6_irq_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> irq_o);

  a_r8_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master && !busy |-> sclk_o);

  a_r8_pulse_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) && master |-> pulses == PW'(DATA_W));
endmodule

bind sync_serial_port ssp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .master  (master),
  .busy    (busy),
  .fall_ev (fall_ev),
  .rise_ev (rise_ev),
  .sclk_o  (sclk_o),
  .rdy_o   (rdy_o),
  .irq_o   (irq_o)
);

// File: tb/sync_serial_port_test.sv
`timescale 1ns/1ps
module sync_serial_port_test;
  localparam int DW = 8;
  localparam int HD = 2;
  localparam logic A_CTRL = 1'b0;
  localparam logic A_DATA = 1'b1;
  // {master, tx_en, rx_en, tx byte, sdi pattern, expected rx buffer}
  localparam int NV = 6;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b1, 8'hA5, 8'h3C, 8'h3C},
    {1'b1, 1'b1, 1'b0, 8'h81, 8'hFF, 8'h3C},
    {1'b0, 1'b1, 1'b1, 8'h5A, 8'hC3, 8'hC3},
    {1'b0, 1'b0, 1'b1, 8'h00, 8'h96, 8'h96},
    {1'b1, 1'b0, 1'b1, 8'h00, 8'h01, 8'h01},
    {1'b0, 1'b1, 1'b0, 8'h7E, 8'h00, 8'h01}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          we = 1'b0, addr = 1'b0;
  logic [DW-1:0] wdata = '0, rdata;
  logic          irq, sclk_o, sclk_oe, sdo, rdy, rdy_oe;
  logic          sclk_s = 1'b1, s_sdi = 1'b0, rdy_pin = 1'b0;
  logic          mode_m = 1'b0;
  logic          m_clr = 1'b1;
  int            m_idx;
  logic [7:0]    m_cap, m_pat = '0, s_cap;
  logic [2:0]    m_sel;
  logic          sdi;

  int n_chk = 0;
  int n_bad = 0;

  sync_serial_port #(.DATA_W(DW), .HALF_DIV(HD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .sclk_i(sclk_s), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe),
    .sdi_i(sdi), .sdo_o(sdo), .rdy_i(rdy_pin), .rdy_o(rdy), .rdy_oe_o(rdy_oe)
  );

  // external slave model for master mode
  always @(negedge sclk_o or posedge m_clr)
    if (m_clr) m_idx <= 0; else m_idx <= m_idx + 1;
  always @(posedge sclk_o or posedge m_clr)
    if (m_clr) m_cap <= '0; else m_cap <= {sdo, m_cap[7:1]};
  assign m_sel = (m_idx == 0) ? 3'd0 : 3'(m_idx - 1);
  assign sdi   = mode_m ? m_pat[m_sel] : s_sdi;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic clr_model();
    m_clr = 1'b1;
    #1 m_clr = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 400 && !irq; i++) @(negedge clk);
  endtask

  // drive slave shift clock bits lo..hi, 12 system clocks per period
  task automatic slave_bits(input int lo, input int hi, input logic [7:0] pat);
    for (int i = lo; i <= hi; i++) begin
      @(negedge clk);
      sclk_s = 1'b0; s_sdi = pat[i];
      repeat (5) @(negedge clk);
      if (i == 0) check("R2 ready high after first fall", rdy, 1'b1);
      s_cap[i] = sdo;
      @(negedge clk);
      sclk_s = 1'b1;
      repeat (5) @(negedge clk);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [DW-1:0] d;
    logic          ms, te, re;
    logic [7:0]    txd, pat, erx, cfg;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_clr = 1'b0;
    @(negedge clk);

    // reset state
    rd(A_CTRL, d);
    check("R5 reset control", d, 8'h00);
    rd(A_DATA, d);
    check("R9 reset rx buffer", d, 8'h00);
    check("R8 reset sclk high", sclk_o, 1'b1);
    check("R1 reset ready high", rdy, 1'b1);
    check("R6 reset irq low", irq, 1'b0);

    for (int v = 0; v < NV; v++) begin
      {ms, te, re, txd, pat, erx} = VEC[v];
      cfg = {5'b0, re, te, ms};
      mode_m = ms; m_pat = pat;
      wr(A_DATA, txd);
      wr(A_CTRL, cfg | 8'h40);
      clr_model();
      check("R6 irq cleared", irq, 1'b0);
      if (!ms) check("R1 idle ready high", rdy, 1'b1);
      wr(A_CTRL, cfg | {3'b0, re, te, 3'b0});
      rd(A_CTRL, d);
      check("R5 trigger reads set", d[4:3], {re, te});
      if (!ms) begin
        check("R1 armed ready low", rdy, 1'b0);
        slave_bits(0, 7, pat);
        repeat (6) @(negedge clk);
      end else begin
        wait_irq();
        @(negedge clk);
        check("R8 eight pulses", m_idx, 8);
        check("R8 idle high after frame", sclk_o, 1'b1);
      end
      check("R6 irq after last bit", irq, 1'b1);
      rd(A_CTRL, d);
      check("R5 trigger clears at end", d[4:3], 2'b00);
      rd(A_DATA, d);
      check("R9 R4 rx buffer", d, erx);
      if (te) check("R4 tx bit order", ms ? m_cap : s_cap, txd);
    end

    // R7: trigger without enables
    mode_m = 1'b1;
    wr(A_CTRL, 8'h40);
    clr_model();
    wr(A_CTRL, 8'h19);
    repeat (40) @(negedge clk);
    rd(A_CTRL, d);
    check("R7 disabled trigger ignored", d[4:3], 2'b00);
    check("R7 no shift clock", m_idx, 0);
    check("R7 no irq", irq, 1'b0);

    // R10: data write during frame
    wr(A_DATA, 8'hF0);
    clr_model();
    wr(A_CTRL, 8'h0B);
    repeat (3) @(negedge clk);
    wr(A_DATA, 8'h0F);
    wait_irq();
    @(negedge clk);
    check("R10 frame keeps loaded byte", m_cap, 8'hF0);
    rd(A_DATA, d);
    check("R9 tx-only keeps rx buffer", d, 8'h01);

    // R6 clear
    check("R6 irq set", irq, 1'b1);
    wr(A_CTRL, 8'h43);
    check("R6 irq cleared by write", irq, 1'b0);

    // R3 pin roles
    check("R3 master rdy not driven", rdy_oe, 1'b0);
    check("R3 master drives sclk", sclk_oe, 1'b1);
    rdy_pin = 1'b1;
    rd(A_CTRL, d);
    check("R3 pin reads 1", d[5], 1'b1);
    rdy_pin = 1'b0;
    rd(A_CTRL, d);
    check("R3 pin reads 0", d[5], 1'b0);
    mode_m = 1'b0;
    wr(A_CTRL, 8'h04);
    check("R3 slave drives rdy", rdy_oe, 1'b1);
    check("R3 slave sclk not driven", sclk_oe, 1'b0);

    // R9: buffer unchanged mid-frame
    wr(A_CTRL, 8'h14);
    check("R1 armed ready low", rdy, 1'b0);
    slave_bits(0, 3, 8'h6D);
    rd(A_DATA, d);
    check("R9 buffer stable mid-frame", d, 8'h01);
    slave_bits(4, 7, 8'h6D);
    repeat (6) @(negedge clk);
    rd(A_DATA, d);
    check("R9 buffer updated at end", d, 8'h6D);
    check("R6 irq slave rx end", irq, 1'b1);

    report();
  end
endmodule